// File: doc/BRIEF.md
# PCI Subtractive Decode Claim Unit

This block sits on a 32-bit PCI bus as a default target. It watches each new transaction's address phase and gives every other agent a fixed positive-decode window to respond. If none of them asserts DEVSEL# in that window, the block claims the cycle itself. It drives its own DEVSEL# low and hands the captured address and command to a downstream bridge through a one-clock forward strobe.

Some commands must never be taken by default: configuration read and write, interrupt acknowledge and special cycles. These are filtered out when the address is captured. A control input, `decode_off`, disables claiming entirely. It is normally tied low (enabled) after reset. If it rises while a decode window is open, the transaction in flight is dropped.

All bus inputs are active-low and are sampled on the rising clock edge. The reset is synchronous and active-high. Edge E0 is the rising edge at which FRAME# is first sampled low after an idle bus. E1, E2, E3 and E4 are the edges that follow it.

Top module: `subdec_claim`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `devsel_out_n` is 1 and `fwd_valid` is 0. A transaction already in progress when reset is released is never claimed; the block first needs one sample with `frame_n` and `irdy_n` both high.
- R2: A transaction starts at an edge where `frame_n` is 0 and the previous sample had both `frame_n` and `irdy_n` at 1. `ad` and `cbe_n` are captured at that edge (E0).
- R3: Suppose `decode_off` is 0 at E0 through E4, `devsel_in_n` is 1 at E1, E2 and E3, and the bus stays busy. Then `devsel_out_n` goes to 0 at E4.
- R4: `fwd_valid` is high for exactly the one cycle after E4, in which `devsel_out_n` first goes low. `fwd_addr` and `fwd_cmd` then hold the values captured at E0.
- R5: A command value on `cbe_n` at E0 of 4'b0000 (interrupt acknowledge), 4'b0001 (special cycle), 4'b1010 (configuration read) or 4'b1011 (configuration write) is never claimed. Every other command is eligible.
- R6: If `devsel_in_n` is sampled 0 at any of E1, E2 or E3, the block does not claim. It takes no new transaction until the bus has been sampled idle.
- R7: Once claimed, `devsel_out_n` stays 0 until an edge samples `frame_n`=1 and `irdy_n`=1, and is 1 after that edge. A new transaction may start at the next edge.
- R8: If `decode_off` is 1 at E0, the transaction is not claimed.
- R9: If `decode_off` is sampled 1 at any of E1 to E4, the transaction is not claimed.
- R10: If the bus is sampled idle during E1 to E4, the block returns to idle without claiming.
- R11: `devsel_in_n` sampled 0 at E4 or later does not prevent or undo a claim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| decode_off | input | 1 | 1 disables default claiming |
| frame_n | input | 1 | FRAME#, active-low |
| irdy_n | input | 1 | IRDY#, active-low |
| devsel_in_n | input | 1 | Wired DEVSEL# from other agents, active-low |
| ad | input | 32 | Address/data bus |
| cbe_n | input | 4 | Command / byte enables |
| devsel_out_n | output | 1 | This block's DEVSEL#, active-low |
| fwd_valid | output | 1 | One-clock claim strobe to the downstream bridge |
| fwd_addr | output | 32 | Captured address |
| fwd_cmd | output | 4 | Captured command |

## Verification
The bench aims other agents' DEVSEL# at each edge of the window in turn, including E4 just past it. A window off by one edge would either claim cycles that another target already owns or give up ones it should take. Each excluded command code is sent next to an eligible neighbour, so a decoder that gets a single bit wrong is caught. The disable input is raised at the start edge, inside the window and on the claim edge itself. The bus is made to go idle early inside the window. Transactions are sent back to back, and reset is released in the middle of a transaction, so a block that ignores the idle requirement claims a cycle it never saw begin.

// File: rtl/subdec_pkg.sv
package subdec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_IGNORE = 2'd2,
    ST_CLAIM  = 2'd3
  } sd_state_e;

  localparam int NUM_EXCL = 4;

  // Command codes that must never be taken by default
  localparam logic [3:0] CMD_INTACK  = 4'b0000;
  localparam logic [3:0] CMD_SPECIAL = 4'b0001;
  localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR  = 4'b1011;

  function automatic logic [3:0] excl_code(input int idx);
    case (idx)
      0:       excl_code = CMD_INTACK;
      1:       excl_code = CMD_SPECIAL;
      2:       excl_code = CMD_CFG_RD;
      default: excl_code = CMD_CFG_WR;
    endcase
  endfunction

endpackage

// File: rtl/subdec_cmd_filter.sv
module subdec_cmd_filter #(
  parameter int CMD_W = 4
) (
  input  logic [CMD_W-1:0] cmd,
  output logic             claimable
);
  import subdec_pkg::*;

  logic [NUM_EXCL-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EXCL; gi++) begin : g_excl
      assign hit[gi] = (cmd == CMD_W'(excl_code(gi)));
    end
  endgenerate

  assign claimable = ~|hit;
endmodule

// File: rtl/subdec_window_timer.sv
module subdec_window_timer #(
  parameter int WINDOW = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic expired
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (step && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == LAST);
endmodule

// File: rtl/subdec_bus_monitor.sv
module subdec_bus_monitor (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  output logic idle_now,
  output logic was_idle
);
  assign idle_now = frame_n & irdy_n;

  // Cleared by reset so a cycle already running at release is not taken
  always_ff @(posedge clk) begin
    if (rst) begin
      was_idle <= 1'b0;
    end else begin
      was_idle <= idle_now;
    end
  end
endmodule

// File: rtl/subdec_claim.sv
module subdec_claim #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int WINDOW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              decode_off,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              devsel_in_n,
  input  logic [ADDR_W-1:0] ad,
  input  logic [CMD_W-1:0]  cbe_n,
  output logic              devsel_out_n,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [CMD_W-1:0]  fwd_cmd
);
  import subdec_pkg::*;

  sd_state_e state_q;
  logic      claimable;
  logic      expired;
  logic      idle_now;
  logic      was_idle;
  logic      start;

  subdec_cmd_filter #(.CMD_W(CMD_W)) u_filter (
    .cmd       (cbe_n),
    .claimable (claimable)
  );

  subdec_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (state_q != ST_DECODE),
    .step    (state_q == ST_DECODE),
    .expired (expired)
  );

  subdec_bus_monitor u_mon (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .idle_now (idle_now),
    .was_idle (was_idle)
  );

  assign start = ~frame_n & was_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      devsel_out_n <= 1'b1;
      fwd_valid    <= 1'b0;
      fwd_addr     <= '0;
      fwd_cmd      <= '0;
    end else begin
      fwd_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            fwd_addr <= ad;
            fwd_cmd  <= cbe_n;
            state_q  <= (decode_off || !claimable) ? ST_IGNORE : ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (idle_now) begin
            state_q <= ST_IDLE;
          end else if (decode_off) begin
            state_q <= ST_IGNORE;
          end else if (expired) begin
            state_q      <= ST_CLAIM;
            devsel_out_n <= 1'b0;
            fwd_valid    <= 1'b1;
          end else if (!devsel_in_n) begin
            state_q <= ST_IGNORE;
          end
        end
        ST_IGNORE: begin
          if (idle_now) state_q <= ST_IDLE;
        end
        default: begin
          if (idle_now) begin
            devsel_out_n <= 1'b1;
            state_q      <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/subdec_claim_checker.sv
module subdec_claim_checker #(
  parameter int CMD_W  = 4,
  parameter int WINDOW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             decode_off,
  input logic             frame_n,
  input logic             irdy_n,
  input logic             devsel_in_n,
  input logic             devsel_out_n,
  input logic             fwd_valid,
  input logic [CMD_W-1:0] fwd_cmd
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      a_r1_reset_idle: assert (devsel_out_n && !fwd_valid);
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |=> !fwd_valid);

  a_r4_strobe_on_claim: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_out_n) |-> fwd_valid);

  a_r4_strobe_drives: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> !devsel_out_n);

  a_r5_no_excluded: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> !(fwd_cmd == CMD_W'(4'b0000) || fwd_cmd == CMD_W'(4'b0001) ||
                    fwd_cmd == CMD_W'(4'b1010) || fwd_cmd == CMD_W'(4'b1011)));

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (!devsel_out_n && frame_n && irdy_n) |=> devsel_out_n);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!devsel_out_n && !(frame_n && irdy_n)) |=> !devsel_out_n);

  a_r9_off_blocks: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> !$past(decode_off));

  generate
    if (WINDOW == 3) begin : g_win3
      // R6: no foreign DEVSEL# seen at E1..E3
      a_r6_window_clear: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> ($past(devsel_in_n, 2) && $past(devsel_in_n, 3) &&
                       $past(devsel_in_n, 4)));
    end
  endgenerate
endmodule

bind subdec_claim subdec_claim_checker #(.CMD_W(CMD_W), .WINDOW(WINDOW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .decode_off   (decode_off),
  .frame_n      (frame_n),
  .irdy_n       (irdy_n),
  .devsel_in_n  (devsel_in_n),
  .devsel_out_n (devsel_out_n),
  .fwd_valid    (fwd_valid),
  .fwd_cmd      (fwd_cmd)
);

// File: tb/subdec_claim_test.sv
module subdec_claim_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        decode_off = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        devsel_in_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = '0;
  logic        devsel_out_n;
  logic        fwd_valid;
  logic [31:0] fwd_addr;
  logic [3:0]  fwd_cmd;

  always #10 clk = ~clk;

  subdec_claim uut (
    .clk(clk), .rst(rst), .decode_off(decode_off), .frame_n(frame_n),
    .irdy_n(irdy_n), .devsel_in_n(devsel_in_n), .ad(ad), .cbe_n(cbe_n),
    .devsel_out_n(devsel_out_n), .fwd_valid(fwd_valid),
    .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // Behavioural reference: phase 0 idle, 1 deciding, 2 ignoring, 3 claimed
  int          m_phase = 0;
  int          m_age = 0;
  bit          m_prev_idle = 0;
  bit          m_devsel_n = 1;
  bit          m_valid = 0;
  logic [31:0] m_addr = '0;
  logic [3:0]  m_cmd = '0;

  function automatic bit is_excluded(logic [3:0] c);
    return (c == 4'b0000) || (c == 4'b0001) || (c == 4'b1010) || (c == 4'b1011);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit idle;
    idle = frame_n && irdy_n;
    m_valid = 0;
    if (rst) begin
      m_phase = 0; m_prev_idle = 0; m_devsel_n = 1; m_addr = '0; m_cmd = '0;
      return;
    end
    if (m_phase == 0) begin
      if (!frame_n && m_prev_idle) begin
        m_addr = ad; m_cmd = cbe_n; m_age = 0;
        m_phase = (decode_off || is_excluded(cbe_n)) ? 2 : 1;
      end
    end else if (m_phase == 1) begin
      m_age++;
      if (idle) m_phase = 0;
      else if (decode_off) m_phase = 2;
      else if (m_age == 4) begin m_phase = 3; m_devsel_n = 0; m_valid = 1; end
      else if (!devsel_in_n) m_phase = 2;
    end else if (m_phase == 2) begin
      if (idle) m_phase = 0;
    end else begin
      if (idle) begin m_phase = 0; m_devsel_n = 1; end
    end
    m_prev_idle = idle;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(devsel_out_n == m_devsel_n, cur_req, "devsel_out_n", devsel_out_n, m_devsel_n);
    chk(fwd_valid == m_valid, cur_req, "fwd_valid", fwd_valid, m_valid);
    if (m_valid) begin
      chk(fwd_addr == m_addr, "R4", "fwd_addr", fwd_addr, m_addr);
      chk(fwd_cmd == m_cmd, "R4", "fwd_cmd", fwd_cmd, m_cmd);
    end
  endtask

  // One transaction; cycle k is sampled at edge Ek
  task automatic txn(logic [31:0] a, logic [3:0] c, int len, int dev_at,
                     int off_at, int idle_at, bit exp_claim, string req);
    bit seen = 0;
    cur_req = req;
    for (int k = 0; k < len + 4; k++) begin
      frame_n     = !(k < len);
      irdy_n      = !(k >= 1 && k <= len);
      if (idle_at >= 0 && k >= idle_at) begin frame_n = 1; irdy_n = 1; end
      devsel_in_n = !(dev_at >= 0 && k >= dev_at && k <= len);
      decode_off  = (off_at >= 0 && k >= off_at);
      ad          = (k == 0) ? a : $urandom;
      cbe_n       = (k == 0) ? c : 4'h0;
      step();
      if (fwd_valid) seen = 1;
    end
    decode_off = 0;
    step();
    chk(seen == exp_claim, req, "claimed", seen, exp_claim);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    // R1: reset state, with a transaction already running at release
    @(negedge clk);
    frame_n = 0; irdy_n = 0;
    step(); step();
    chk(devsel_out_n == 1'b1, "R1", "devsel in reset", devsel_out_n, 1);
    chk(fwd_valid == 1'b0, "R1", "valid in reset", fwd_valid, 0);
    rst = 0;
    cur_req = "R1";
    for (int k = 0; k < 7; k++) step();
    frame_n = 1; irdy_n = 1;
    step(); step();

    // R2 R3 R4: basic claims with eligible commands
    txn(32'h0000_0300, 4'b0011, 7, -1, -1, -1, 1, "R3");
    txn(32'hDEAD_BEEF, 4'b0010, 7, -1, -1, -1, 1, "R2");
    txn(32'h1234_5678, 4'b0110, 5, -1, -1, -1, 1, "R4");

    // R5: excluded commands and eligible neighbours
    txn(32'h0000_0000, 4'b0000, 7, -1, -1, -1, 0, "R5");
    txn(32'h0000_0004, 4'b0001, 7, -1, -1, -1, 0, "R5");
    txn(32'h8000_0000, 4'b1010, 7, -1, -1, -1, 0, "R5");
    txn(32'h8000_0004, 4'b1011, 7, -1, -1, -1, 0, "R5");
    txn(32'h8000_0008, 4'b1110, 7, -1, -1, -1, 1, "R5");
    txn(32'h8000_000C, 4'b0111, 7, -1, -1, -1, 1, "R5");

    // R6: foreign DEVSEL# at each window edge
    txn(32'h0000_0100, 4'b0011, 7, 1, -1, -1, 0, "R6");
    txn(32'h0000_0104, 4'b0011, 7, 2, -1, -1, 0, "R6");
    txn(32'h0000_0108, 4'b0011, 7, 3, -1, -1, 0, "R6");

    // R11: foreign DEVSEL# after the window
    txn(32'h0000_010C, 4'b0011, 7, 4, -1, -1, 1, "R11");

    // R8 and R9: disable at start, inside window, at claim edge
    txn(32'h0000_0200, 4'b0010, 7, -1, 0, -1, 0, "R8");
    txn(32'h0000_0204, 4'b0010, 7, -1, 2, -1, 0, "R9");
    txn(32'h0000_0208, 4'b0010, 7, -1, 4, -1, 0, "R9");
    txn(32'h0000_020C, 4'b0010, 7, -1, 5, -1, 1, "R9");

    // R10: bus idle inside the window
    txn(32'h0000_0400, 4'b0011, 7, -1, -1, 2, 0, "R10");
    txn(32'h0000_0404, 4'b0011, 7, -1, -1, 4, 0, "R10");

    // R7: long hold and back-to-back claims
    txn(32'h0000_0500, 4'b0011, 12, -1, -1, -1, 1, "R7");
    txn(32'h0000_0504, 4'b0010, 6, -1, -1, -1, 1, "R7");
    txn(32'h0000_0508, 4'b0011, 6, -1, -1, -1, 1, "R7");

    summary();
  end
endmodule